// File: doc/BRIEF.md
# OTP Fuse Array Register Front End

This block is the register-mapped front end of a one-time-programmable fuse array. Software sees a small 32-bit register bus. Through it, software sets the fuse address and a group of control words: I/O, select, chip enable, clock, data in, strobe, program, test control, test mode, test repeat, test register, trim and write enable. Software reads fuse words back through a read-only data-out register.

The fuse contents are fixed once reset releases. Every word is all-ones, except a pair of words at a parameterised serial index. The first word of the pair holds a configurable serial value and the next word holds its bitwise complement. Data-out returns a real fuse word only while chip enable, strobe and trim are all switched on. In every other case it returns 0xFF. Real fuse programming, programming timing and analog trim are not modelled.

Top module: `otp_fuse_regs`

## Requirements
- R1: After reset, every control register reads 0 and `rdata` is 0.
- R2: Each control register reads back the last 32-bit value written to it. The byte offsets are: address 0x00, I/O 0x04, select 0x08, chip enable 0x0C, clock 0x10, data in 0x14, data out 0x18, strobe 0x1C, program 0x20, test control 0x24, test mode 0x28, test repeat 0x2C, test register 0x30, trim 0x34, write enable 0x38.
- R3: A write to the address register keeps only the low ADDR_W bits of `wdata`. The upper bits read back as zero.
- R4: When bit 0 of chip enable (0x0C), bit 0 of strobe (0x1C) and bit 0 of trim (0x34) are all 1, a read of data-out returns the fuse word at the stored address.
- R5: When any of those three bits is 0, a read of data-out returns 0x000000FF.
- R6: The fuse word at index SERIAL_IDX is SERIAL. The word at SERIAL_IDX+1 is ~SERIAL. Every other word is 0xFFFFFFFF.
- R7: Writes to data-out (0x18) leave every register unchanged.
- R8: An offset with bits [1:0] not zero, or an offset above 0x38, is unmapped. A read of it returns 0 and a write to it changes nothing.
- R9: `rdata` takes the read result on the clock edge where `rd_en` is sampled high. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | REG_AW | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |

## Verification
The assertions expect that `addr` is stable and meaningful whenever `rd_en` or `wr_en` is high. They also expect that a read and a write are never issued in the same cycle. That lets the read checks ignore a register that is changing under them.

The bench drives every strobe for exactly one cycle, with inputs set on the falling edge. It never raises both strobes together. It sweeps every byte offset, every fuse address and all eight combinations of the three enables.

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs #(
  parameter int          ADDR_W     = 12,
  parameter int          REG_AW     = 8,
  parameter int          SERIAL_IDX = 'hFC,
  parameter logic [31:0] SERIAL     = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata
);
  localparam int NREG  = 15;
  localparam int I_ADR = 0;
  localparam int I_CE  = 3;
  localparam int I_OUT = 6;
  localparam int I_STB = 7;
  localparam int I_TRM = 13;
  localparam logic [ADDR_W-1:0] SER0 = ADDR_W'(SERIAL_IDX);
  localparam logic [ADDR_W-1:0] SER1 = ADDR_W'(SERIAL_IDX + 1);

  logic [31:0] regs [16];
  logic [31:0] rd_val;
  logic [31:0] fuse_word;

  wire [3:0] idx    = addr[5:2];
  wire       mapped = (addr[1:0] == 2'b00) && (addr[REG_AW-1:6] == '0) && (idx < 4'(NREG));
  wire       is_out = mapped && (idx == 4'(I_OUT));
  wire       fuse_on = regs[I_CE][0] & regs[I_STB][0] & regs[I_TRM][0];
  wire [ADDR_W-1:0] fuse_adr = regs[I_ADR][ADDR_W-1:0];

  always_comb begin
    if (fuse_adr == SER0)      fuse_word = SERIAL;
    else if (fuse_adr == SER1) fuse_word = ~SERIAL;
    else                       fuse_word = '1;
  end

  always_comb begin
    if (!mapped)     rd_val = '0;
    else if (is_out) rd_val = fuse_on ? fuse_word : 32'h0000_00FF;
    else             rd_val = regs[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && mapped && !is_out)
        regs[idx] <= (idx == 4'(I_ADR)) ? {{(32-ADDR_W){1'b0}}, wdata[ADDR_W-1:0]} : wdata;
      if (rd_en) rdata <= rd_val;
    end
  end

  // R5
  gated_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && is_out && !fuse_on) |=> (rdata == 32'h0000_00FF));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == '0));
  // R3
  addr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && mapped && idx == 4'(I_ADR)) |=> (rdata[31:ADDR_W] == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && $past(rst_n)) |=> $stable(rdata));
  // R7
  out_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_out) |=> $stable(fuse_on));
endmodule

// File: tb/sim_otp_fuse_regs.sv
module sim_otp_fuse_regs;
  localparam int AW = 12;
  localparam int SIDX = 'hFC;
  localparam logic [31:0] SER = 32'h1234_5678;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata, got;
  int total = 0, bad = 0, cyc = 0;
  logic [31:0] shadow [15];

  always #2.5 clk = ~clk;

  otp_fuse_regs u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                    .wdata(wdata), .rd_en(rd_en), .rdata(rdata));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] fuse_exp(input int i);
    if (i == SIDX) return SER;
    if (i == SIDX + 1) return ~SER;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check_regs(input string r);
    for (int k = 0; k < 15; k++) if (k != 6) begin
      rd(8'(k*4), got); chk(r, got, shadow[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rdata", rdata, 0);
    for (int k = 0; k < 15; k++) shadow[k] = 0;
    check_regs("R1");
    rd(8'h18, got); chk("R1/R5 dout after reset", got, 32'hFF);

    // R2 / R3: write every control register with distinct patterns
    for (int k = 0; k < 15; k++) if (k != 6) begin
      logic [31:0] v = 32'hA5C3_0000 ^ (k * 32'h0101_1111);
      wr(8'(k*4), v);
      shadow[k] = (k == 0) ? (v & ((1 << AW) - 1)) : v;
    end
    check_regs("R2");
    wr(8'h00, 32'hFFFF_FFFF); shadow[0] = (1 << AW) - 1;
    rd(8'h00, got); chk("R3 mask", got, shadow[0]);

    // R7: write to data-out changes nothing
    wr(8'h18, 32'h0);
    check_regs("R7");

    // R8: unmapped and misaligned offsets
    for (int a = 0; a < 256; a++) if ((a % 4) != 0 || a > 'h38) begin
      rd(8'(a), got); chk("R8 read", got, 0);
    end
    wr(8'h01, 32'h0); wr(8'h0D, 32'h0); wr(8'h3C, 32'h0); wr(8'hFC, 32'h0);
    check_regs("R8 write");

    // R4 / R5: all enable combinations at the serial index
    wr(8'h00, SIDX); shadow[0] = SIDX;
    for (int m = 0; m < 8; m++) begin
      wr(8'h0C, {31'h7, m[0]}); wr(8'h1C, {31'h3, m[1]}); wr(8'h34, {31'h1, m[2]});
      rd(8'h18, got);
      chk(m == 7 ? "R4 gate" : "R5 gate", got, m == 7 ? SER : 32'hFF);
    end

    // R6 / R4: sweep every fuse address
    for (int i = 0; i < (1 << AW); i++) begin
      wr(8'h00, 32'hABC0_0000 | i);
      rd(8'h18, got); chk("R6 fuse", got, fuse_exp(i));
    end

    // R9: rdata holds when rd_en stays low
    rd(8'h04, got);
    wr(8'h04, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 hold", rdata, got);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule